// File: doc/BRIEF.md
# And-Not Fact Node with Flow Control

This block is one gate of a network that evaluates logic by passing facts between nodes over handshakes. It computes `c = a & ~b` over two valued input events. The result is decided as soon as the facts already received settle it. An `a` of 0, or a `b` of 1, forces a 0 without waiting for the other operand. A 1 needs both operands. Whatever the order of arrival, the result leaves the node once per logical tick.

Each input is a level request (`*_valid_i` with `*_val_i`) that the source holds until the node answers with a one-cycle free pulse. The output leaves as a one-cycle `c_valid_o` pulse, and only while the node holds a credit that downstream returns with `c_free_i`. Once both inputs have been consumed and the result has been sent, the node clears itself for the next tick. No extra protocol is involved. Three wait outputs tell a scheduler what the node is still blocked on.

Top module: `andnot_fact_node`

## Requirements
- R1: After reset, `c_valid_o`, `a_free_o` and `b_free_o` are 0, `a_wait_o` and `b_wait_o` are 1, and `c_free_wait_o` is 0 (one output credit is granted at reset).
- R2: An `a` fact of value 0 forces the result to 0. With a credit held, `c_valid_o` pulses with `c_val_o`=0 on the clock edge after the capture, even if `b` has not arrived.
- R3: A `b` fact of value 1 forces the result to 0 in the same way, even if `a` has not arrived.
- R4: `c_val_o`=1 is sent only when the tick has captured `a`=1 and `b`=0.
- R5: Exactly one `c_valid_o` pulse is produced per tick, even when both early-zero conditions hold.
- R6: An input is captured on a clock edge where its valid is high and the node holds no fact for that port. Its free output is high for exactly the following cycle.
- R7: `c_valid_o` pulses only while a credit is held. A credit is consumed by each pulse and restored by a `c_free_i` pulse. `c_free_wait_o` is 1 exactly while no credit is held.
- R8: Once both inputs have been captured and the result sent, the node clears both facts on the next edge. `a_wait_o` and `b_wait_o` return to 1 and new values are accepted.
- R9: A valid request on a port that already holds a fact for the current tick is held off. It gives no free pulse and does not change the stored value.
- R10: `a_wait_o` and `b_wait_o` are 1 exactly while no fact is held for that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_valid_i | input | 1 | Operand a request, held until freed |
| a_val_i | input | 1 | Operand a value |
| b_valid_i | input | 1 | Operand b request, held until freed |
| b_val_i | input | 1 | Operand b value |
| c_free_i | input | 1 | Downstream returns an output credit |
| a_free_o | output | 1 | Operand a consumed (one-cycle pulse) |
| b_free_o | output | 1 | Operand b consumed (one-cycle pulse) |
| c_valid_o | output | 1 | Result event (one-cycle pulse) |
| c_val_o | output | 1 | Result value |
| a_wait_o | output | 1 | Node is waiting for operand a |
| b_wait_o | output | 1 | Node is waiting for operand b |
| c_free_wait_o | output | 1 | Node is waiting for an output credit |

## Verification
The hardest state to reach is a decided result that is blocked only by a missing credit while the next tick's operands are already queued. Reaching it means downstream must hold back `c_free_i` across a whole tick. The stimulus turns off the automatic credit responder, completes one tick, and then drives a second tick. It observes the stall and `c_free_wait_o`, then returns a single credit by hand. Hold-off is reached by keeping a request high with a changed value after its free pulse. Random ticks mix operand order and delays with credit latencies of zero to three cycles.

// File: rtl/andnot_pkg.sv
package andnot_pkg;
  localparam int NUM_IN = 2;
  localparam int IDX_A  = 0;
  localparam int IDX_B  = 1;

  typedef struct packed {
    logic held;
    logic val;
  } fact_t;
endpackage

// File: rtl/fact_port.sv
module fact_port
  import andnot_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  logic  val_i,
  input  logic  clear_i,
  output fact_t fact_o,
  output logic  free_o,
  output logic  wait_o
);
  fact_t fact_q;
  logic  take;

  assign take = valid_i && !fact_q.held;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fact_q <= '0;
      free_o <= 1'b0;
    end else begin
      free_o <= take;
      if (take)         fact_q <= '{held: 1'b1, val: val_i};
      else if (clear_i) fact_q.held <= 1'b0;
    end
  end

  assign fact_o = fact_q;
  assign wait_o = !fact_q.held;

  assert_free_after_take_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_o |-> fact_q.held && $past(valid_i));
  assert_hold_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fact_q.held && !clear_i) |=> !free_o && $stable(fact_q.val));
endmodule

// File: rtl/andnot_decide.sv
module andnot_decide
  import andnot_pkg::*;
(
  input  fact_t a_i,
  input  fact_t b_i,
  output logic  decided_o,
  output logic  value_o
);
  logic zero_by_a, zero_by_b, one_by_both;

  assign zero_by_a   = a_i.held && !a_i.val;
  assign zero_by_b   = b_i.held &&  b_i.val;
  assign one_by_both = a_i.held && a_i.val && b_i.held && !b_i.val;

  assign decided_o = zero_by_a || zero_by_b || one_by_both;
  // every active decision votes; the votes are ANDed into one value
  assign value_o = (!zero_by_a) && (!zero_by_b) && one_by_both;
endmodule

// File: rtl/emit_ctrl.sv
module emit_ctrl #(
  parameter bit CREDIT_AT_RESET = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic decided_i,
  input  logic value_i,
  input  logic all_in_i,
  input  logic c_free_i,
  output logic c_valid_o,
  output logic c_val_o,
  output logic tick_done_o,
  output logic credit_o
);
  logic credit_q, sent_q, emit;

  assign emit        = decided_i && credit_q && !sent_q;
  assign tick_done_o = all_in_i && sent_q;
  assign credit_o    = credit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      credit_q  <= CREDIT_AT_RESET;
      sent_q    <= 1'b0;
      c_valid_o <= 1'b0;
      c_val_o   <= 1'b0;
    end else begin
      c_valid_o <= emit;
      if (emit) c_val_o <= value_i;
      if (c_free_i)  credit_q <= 1'b1;
      else if (emit) credit_q <= 1'b0;
      if (emit)             sent_q <= 1'b1;
      else if (tick_done_o) sent_q <= 1'b0;
    end
  end

  assert_single_emit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_valid_o |-> sent_q && !$past(c_valid_o));
  assert_credit_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_valid_o |-> $past(credit_q));
endmodule

// File: rtl/andnot_fact_node.sv
module andnot_fact_node
  import andnot_pkg::*;
#(
  parameter bit CREDIT_AT_RESET = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_valid_i,
  input  logic a_val_i,
  input  logic b_valid_i,
  input  logic b_val_i,
  input  logic c_free_i,
  output logic a_free_o,
  output logic b_free_o,
  output logic c_valid_o,
  output logic c_val_o,
  output logic a_wait_o,
  output logic b_wait_o,
  output logic c_free_wait_o
);
  logic [NUM_IN-1:0] in_valid, in_val, in_free, in_wait;
  fact_t             facts [NUM_IN];
  logic              decided, value, tick_done, credit, all_in;

  assign in_valid = {b_valid_i, a_valid_i};
  assign in_val   = {b_val_i, a_val_i};

  for (genvar g = 0; g < NUM_IN; g++) begin : g_port
    fact_port u_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (in_valid[g]),
      .val_i   (in_val[g]),
      .clear_i (tick_done),
      .fact_o  (facts[g]),
      .free_o  (in_free[g]),
      .wait_o  (in_wait[g])
    );
  end

  assign all_in = facts[IDX_A].held && facts[IDX_B].held;

  andnot_decide u_decide (
    .a_i       (facts[IDX_A]),
    .b_i       (facts[IDX_B]),
    .decided_o (decided),
    .value_o   (value)
  );

  emit_ctrl #(.CREDIT_AT_RESET(CREDIT_AT_RESET)) u_emit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .decided_i   (decided),
    .value_i     (value),
    .all_in_i    (all_in),
    .c_free_i    (c_free_i),
    .c_valid_o   (c_valid_o),
    .c_val_o     (c_val_o),
    .tick_done_o (tick_done),
    .credit_o    (credit)
  );

  assign a_free_o      = in_free[IDX_A];
  assign b_free_o      = in_free[IDX_B];
  assign a_wait_o      = in_wait[IDX_A];
  assign b_wait_o      = in_wait[IDX_B];
  assign c_free_wait_o = !credit;

  assert_one_needs_both_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_valid_o && c_val_o) |-> $past(!a_wait_o && !b_wait_o && facts[IDX_A].val && !facts[IDX_B].val));
  assert_early_zero_a_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (u_emit.sent_q == 1'b0 && credit && facts[IDX_A].held && !facts[IDX_A].val) |=> c_valid_o && !c_val_o);
  assert_early_zero_b_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (u_emit.sent_q == 1'b0 && credit && facts[IDX_B].held && facts[IDX_B].val) |=> c_valid_o && !c_val_o);
  assert_tick_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_done |=> a_wait_o && b_wait_o);
endmodule

// File: tb/tb_andnot_fact_node.sv
module tb_andnot_fact_node;
  logic clk = 1'b0, rst_n = 1'b0;
  logic a_valid_i = 0, a_val_i = 0, b_valid_i = 0, b_val_i = 0, c_free_i = 0;
  logic a_free_o, b_free_o, c_valid_o, c_val_o, a_wait_o, b_wait_o, c_free_wait_o;

  int checks = 0, errors = 0, cycles = 0;
  int c_count = 0;
  bit c_last = 0;
  bit auto_free = 1;
  bit manual_free = 0;
  int free_dly = -1;

  always #2.5 clk = ~clk;

  andnot_fact_node dut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_valid_i(a_valid_i), .a_val_i(a_val_i),
    .b_valid_i(b_valid_i), .b_val_i(b_val_i),
    .c_free_i(c_free_i),
    .a_free_o(a_free_o), .b_free_o(b_free_o),
    .c_valid_o(c_valid_o), .c_val_o(c_val_o),
    .a_wait_o(a_wait_o), .b_wait_o(b_wait_o),
    .c_free_wait_o(c_free_wait_o)
  );

  function automatic bit exp_c(bit a, bit b);
    return a & ~b;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor and downstream credit responder, away from the edge
  always @(posedge clk) begin
    #1;
    cycles++;
    c_free_i = 1'b0;
    if (c_valid_o) begin
      c_count++;
      c_last = c_val_o;
      if (auto_free) free_dly = $urandom_range(0, 3);
    end
    if (manual_free) begin
      c_free_i = 1'b1;
      manual_free = 0;
    end else if (free_dly == 0) begin
      c_free_i = 1'b1;
      free_dly = -1;
    end else if (free_dly > 0) free_dly--;
  end

  task automatic send(int p, bit v, int dly);
    repeat (dly) @(negedge clk);
    if (p == 0) begin a_valid_i = 1; a_val_i = v; end
    else        begin b_valid_i = 1; b_val_i = v; end
    do @(negedge clk); while (!(p == 0 ? a_free_o : b_free_o));
    if (p == 0) a_valid_i = 0; else b_valid_i = 0;
  endtask

  task automatic wait_c(int lim);
    for (int i = 0; i < lim && c_count == 0; i++) @(negedge clk);
  endtask

  initial begin
    int sa, sb;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 c_valid", c_valid_o, 0);
    check("R1 free", a_free_o | b_free_o, 0);
    check("R1 wait a/b", {a_wait_o, b_wait_o}, 3);
    check("R1 credit", c_free_wait_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 early zero from a, b absent
    c_count = 0;
    send(0, 0, 0);
    check("R6 free then clear", a_free_o, 1);
    @(negedge clk);
    check("R6 free one cycle", a_free_o, 0);
    check("R2 emitted before b", c_count, 1);
    check("R2 value", c_last, 0);
    check("R10 b wait", b_wait_o, 1);
    check("R10 a held", a_wait_o, 0);
    send(1, 1, 0);
    repeat (3) @(negedge clk);
    check("R5 no second emit", c_count, 1);
    check("R8 tick cleared", {a_wait_o, b_wait_o}, 3);

    // R3 early zero from b, a absent
    c_count = 0;
    send(1, 1, 0);
    repeat (2) @(negedge clk);
    check("R3 emitted before a", c_count, 1);
    check("R3 value", c_last, 0);
    send(0, 1, 0);
    repeat (3) @(negedge clk);
    check("R5 single emit", c_count, 1);

    // R9 hold-off: a held, request kept high with other value
    c_count = 0;
    send(0, 1, 0);
    a_valid_i = 1; a_val_i = 0;
    sa = 0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); sa += a_free_o; end
    check("R9 no free while held", sa, 0);
    a_valid_i = 0;
    send(1, 0, 0);
    wait_c(10);
    check("R4 one emitted", c_count, 1);
    check("R9 value kept", c_last, 1);
    repeat (3) @(negedge clk);

    // R7 credit withheld across a tick
    repeat (6) @(negedge clk);
    auto_free = 0;
    c_count = 0;
    fork send(0, 1, 0); send(1, 0, 1); join
    wait_c(10);
    check("R7 first emit", c_count, 1);
    repeat (2) @(negedge clk);
    check("R7 wait credit", c_free_wait_o, 1);
    c_count = 0;
    fork send(0, 0, 0); send(1, 0, 0); join
    repeat (5) @(negedge clk);
    check("R7 stalled", c_count, 0);
    check("R7 still waiting", c_free_wait_o, 1);
    manual_free = 1;
    auto_free = 1;
    wait_c(10);
    check("R7 emit after credit", c_count, 1);
    check("R7 value", c_last, 0);
    repeat (6) @(negedge clk);

    // random ticks
    for (int t = 0; t < 60; t++) begin
      bit va, vb;
      va = 1'($urandom_range(0, 1));
      vb = 1'($urandom_range(0, 1));
      sa = $urandom_range(0, 4);
      sb = $urandom_range(0, 4);
      c_count = 0;
      fork send(0, va, sa); send(1, vb, sb); join
      wait_c(20);
      repeat (3) @(negedge clk);
      check("R5 one per tick", c_count, 1);
      check("R4 value", c_last, exp_c(va, vb));
    end
    repeat (6) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule